// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel audio sample words into one serial data line. It does not make its own serial clocks. It follows a bit clock and a frame signal that arrive from outside, and it oversamples both with the faster system clock. Five framing schemes are available: two-channel I2S, two-channel left-justified, two-channel right-justified, multi-slot TDM marked by a level frame signal, and multi-slot TDM marked by a one-bit pulse. They differ in two ways: which frame-signal edge opens a frame, and how many bit periods the most significant bit waits after the slot boundary.

Every slot is 32 bit periods long. At each slot boundary the block moves a sample from a one-entry holding register into its output word. It then raises a one-cycle request that names the slot the host must fill next. If the host has not refilled the holding register by the next boundary, the previous word is sent again and an underrun pulse is raised. Outside the active data bits the line is held at zero.

Top module: `audio_ser_tx`

## Requirements
- R1: `sdo` changes only in the system-clock cycle that directly follows a detected falling edge of `bclk`. It is stable while `bclk` is high.
- R2: With `fmt`=0 (I2S), a falling `fclk` edge starts a frame. The MSB of slot n is driven at frame bit position 32n+1. A rising `fclk` edge seen before the first frame start does not start a frame.
- R3: With `fmt`=1 (left-justified), a rising `fclk` edge starts a frame, and the MSB of slot n is driven at position 32n, in the same bit period as the edge. In the three two-channel modes, `tdm_16` has no effect, and there are always 2 slots.
- R4: With `fmt`=2 (right-justified), a rising `fclk` edge starts a frame. The MSB of slot n is delayed by 32 minus the word length: 8 bit periods for 24-bit words and 16 for 16-bit words.
- R5: With `fmt`=3 (TDM, level frame signal), a falling `fclk` edge starts a frame, and the MSB of slot n sits at position 32n+1. `tdm_16`=1 selects 16 slots, and `tdm_16`=0 selects 8.
- R6: With `fmt`=4 (TDM, pulse frame signal), the rising edge of a one-bit `fclk` pulse starts a frame. The MSB of slot n sits at position 32n+1, and the slot count is set as in R5.
- R7: `sdo` is 0 on every bit outside the active data bits. This covers bits before the word and after it within a slot, all bits before the first frame start, and all bits after the last slot until the next frame start.
- R8: At each slot boundary the holding register is loaded into the output word. `smp_req` pulses for one cycle in that boundary's bit period, which is at least 32 bit periods before the next slot's first data bit. `smp_req_slot` gives the next slot's index, and it wraps to 0 after the last slot.
- R9: If the holding register is empty at a slot boundary, the previous word is sent again and `underrun` pulses for one cycle. When the host answers every request, `underrun` never pulses.
- R10: With `wlen_24`=1 the word is `smp_data[23:0]`. With `wlen_24`=0 it is `smp_data[15:0]`. In both cases bits are sent MSB first.
- R11: After reset, `sdo`, `smp_req` and `underrun` are 0, the holding register is empty and the output word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `bclk` |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Framing scheme: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM level, 4 TDM pulse |
| wlen_24 | input | 1 | 1 selects 24-bit words, 0 selects 16-bit words |
| tdm_16 | input | 1 | TDM slot count: 1 for 16 slots, 0 for 8 |
| bclk | input | 1 | External bit clock, oversampled by `clk` |
| fclk | input | 1 | External frame signal (level or pulse) |
| smp_data | input | 24 | Sample word for the next slot |
| smp_valid | input | 1 | Writes `smp_data` into the holding register |
| smp_req | output | 1 | One-cycle request for the next slot's sample |
| smp_req_slot | output | 4 | Index of the slot the request is for |
| underrun | output | 1 | One-cycle pulse when a slot starts with no new sample |
| sdo | output | 1 | Serial data line |

## Verification
The hardest case to reach from the ports is a slot boundary that arrives while the holding register is empty, after a real sample has already gone out. To build it, the bench preloads exactly one sample and then stops answering requests. The first slot then carries that sample, and the second slot must repeat it bit for bit while `underrun` pulses. Edges of the wrong polarity are exercised in the idle bits before the first frame of every format, where any false start would show up as data on the line.

// File: rtl/atx_pkg.sv
package atx_pkg;

    typedef enum logic [2:0] {
        FMT_I2S     = 3'd0,
        FMT_LJ      = 3'd1,
        FMT_RJ      = 3'd2,
        FMT_TDM_LVL = 3'd3,
        FMT_TDM_PLS = 3'd4
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic wlen_24;
        logic tdm_16;
    } cfg_t;

    // Edge of the frame signal that opens a frame for each scheme.
    function automatic logic start_on_rise(fmt_e f);
        return (f == FMT_LJ) || (f == FMT_RJ) || (f == FMT_TDM_PLS);
    endfunction

    function automatic logic is_tdm(fmt_e f);
        return (f == FMT_TDM_LVL) || (f == FMT_TDM_PLS);
    endfunction

endpackage

// File: rtl/atx_edge_sense.sv
module atx_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic fclk,
    input  logic rise_start,
    output logic tick,
    output logic frame_start
);
    logic bclk_d;
    logic fclk_last;
    logic primed;

    assign tick        = bclk_d & ~bclk;
    assign frame_start = tick & primed & (fclk != fclk_last) & (fclk == rise_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d    <= 1'b0;
            fclk_last <= 1'b0;
            primed    <= 1'b0;
        end else begin
            bclk_d <= bclk;
            if (tick) begin
                fclk_last <= fclk;
                primed    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/atx_slot_counter.sv
module atx_slot_counter #(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             frame_start,
    output logic             adv,
    output logic             synced_q,
    output logic [POS_W-1:0] nxt_pos
);
    localparam logic [POS_W-1:0] POS_SAT = '1;

    logic [POS_W-1:0] pos_q;

    assign adv     = frame_start | (tick & synced_q);
    assign nxt_pos = frame_start        ? '0 :
                     (pos_q == POS_SAT) ? pos_q :
                                          pos_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= POS_SAT;
            synced_q <= 1'b0;
        end else begin
            if (adv) pos_q <= nxt_pos;
            if (frame_start) synced_q <= 1'b1;
        end
    end

    // R8: every detected frame start puts the count back at position zero
    a_r8_frame_restarts_count: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (pos_q == '0));

endmodule

// File: rtl/atx_sample_hold.sv
module atx_sample_hold #(
    parameter int DATA_W = 24,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_W-1:0] nxt_slot,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic [DATA_W-1:0] word_nxt,
    output logic              req,
    output logic [SLOT_W-1:0] req_slot,
    output logic              underrun
);
    logic [DATA_W-1:0] hold_q;
    logic              hold_v;
    logic [DATA_W-1:0] word_q;

    assign word_nxt = (load && hold_v) ? hold_q : word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            hold_v   <= 1'b0;
            word_q   <= '0;
            req      <= 1'b0;
            req_slot <= '0;
            underrun <= 1'b0;
        end else begin
            req      <= load;
            underrun <= load & ~hold_v;
            if (load) begin
                word_q   <= word_nxt;
                req_slot <= nxt_slot;
            end
            if (in_valid) begin
                hold_q <= in_data;
                hold_v <= 1'b1;
            end else if (load) begin
                hold_v <= 1'b0;
            end
        end
    end

    // R9: a boundary with an empty holding register keeps the old word
    a_r9_repeat_on_underrun: assert property (@(posedge clk) disable iff (rst)
        (load && !hold_v) |=> $stable(word_q));

    // R8: the output word only moves at a slot boundary
    a_r8_word_moves_at_load: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_q) |-> $past(load));

endmodule

// File: rtl/atx_bit_select.sv
module atx_bit_select #(
    parameter int DATA_W = 24,
    parameter int LOC_W  = 5
) (
    input  logic [LOC_W:0]    loc,
    input  logic [LOC_W:0]    off,
    input  logic [LOC_W:0]    wl,
    input  logic [DATA_W-1:0] word,
    output logic              bit_out
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int EXT_W = 2 ** IDX_W;
    localparam logic [LOC_W:0] ONE = 1;

    logic [LOC_W:0]     rel;
    logic [LOC_W:0]     idx_full;
    logic               active;
    logic [EXT_W-1:0]   wext;

    always_comb begin
        wext              = '0;
        wext[DATA_W-1:0]  = word;
        rel               = loc - off;
        active            = (loc >= off) && (rel < wl);
        idx_full          = wl - rel - ONE;
        bit_out           = active ? wext[idx_full[IDX_W-1:0]] : 1'b0;
    end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import atx_pkg::*;
#(
    parameter int WORD_SHORT   = 16,
    parameter int WORD_LONG    = 24,
    parameter int SLOT_BITS    = 32,
    parameter int TDM_SLOTS_LO = 8,
    parameter int TDM_SLOTS_HI = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [2:0]                      fmt,
    input  logic                            wlen_24,
    input  logic                            tdm_16,
    input  logic                            bclk,
    input  logic                            fclk,
    input  logic [WORD_LONG-1:0]            smp_data,
    input  logic                            smp_valid,
    output logic                            smp_req,
    output logic [$clog2(TDM_SLOTS_HI)-1:0] smp_req_slot,
    output logic                            underrun,
    output logic                            sdo
);
    localparam int LOC_W  = $clog2(SLOT_BITS);
    localparam int SLOT_W = $clog2(TDM_SLOTS_HI);
    localparam int CNT_W  = SLOT_W + 1;
    localparam int POS_W  = CNT_W + LOC_W;
    localparam int STEREO = 2;

    cfg_t              cfg;
    logic              tick;
    logic              frame_start;
    logic              adv;
    logic              synced_q;
    logic [POS_W-1:0]  nxt_pos;
    logic [LOC_W:0]    wl;
    logic [LOC_W:0]    off;
    logic [LOC_W:0]    loc;
    logic [CNT_W-1:0]  nslots;
    logic [CNT_W-1:0]  slot_cur;
    logic [CNT_W-1:0]  slot_inc;
    logic [SLOT_W-1:0] nxt_req_slot;
    logic              in_range;
    logic              load;
    logic [WORD_LONG-1:0] word_nxt;
    logic              bit_val;

    assign cfg = '{fmt: fmt_e'(fmt), wlen_24: wlen_24, tdm_16: tdm_16};

    // Word length and MSB offset from the slot boundary.
    assign wl = cfg.wlen_24 ? (LOC_W+1)'(WORD_LONG) : (LOC_W+1)'(WORD_SHORT);

    always_comb begin
        case (cfg.fmt)
            FMT_LJ:  off = '0;
            FMT_RJ:  off = (LOC_W+1)'(SLOT_BITS) - wl;
            default: off = (LOC_W+1)'(1);
        endcase
        if (is_tdm(cfg.fmt))
            nslots = cfg.tdm_16 ? CNT_W'(TDM_SLOTS_HI) : CNT_W'(TDM_SLOTS_LO);
        else
            nslots = CNT_W'(STEREO);
    end

    atx_edge_sense u_edge (
        .clk         (clk),
        .rst         (rst),
        .bclk        (bclk),
        .fclk        (fclk),
        .rise_start  (start_on_rise(cfg.fmt)),
        .tick        (tick),
        .frame_start (frame_start)
    );

    atx_slot_counter #(.POS_W(POS_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .frame_start (frame_start),
        .adv         (adv),
        .synced_q    (synced_q),
        .nxt_pos     (nxt_pos)
    );

    assign slot_cur     = nxt_pos[POS_W-1:LOC_W];
    assign loc          = {1'b0, nxt_pos[LOC_W-1:0]};
    assign in_range     = slot_cur < nslots;
    assign load         = adv && in_range && (nxt_pos[LOC_W-1:0] == '0);
    assign slot_inc     = slot_cur + 1'b1;
    assign nxt_req_slot = (slot_inc == nslots) ? '0 : slot_inc[SLOT_W-1:0];

    atx_sample_hold #(.DATA_W(WORD_LONG), .SLOT_W(SLOT_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .nxt_slot (nxt_req_slot),
        .in_data  (smp_data),
        .in_valid (smp_valid),
        .word_nxt (word_nxt),
        .req      (smp_req),
        .req_slot (smp_req_slot),
        .underrun (underrun)
    );

    atx_bit_select #(.DATA_W(WORD_LONG), .LOC_W(LOC_W)) u_sel (
        .loc     (loc),
        .off     (off),
        .wl      (wl),
        .word    (word_nxt),
        .bit_out (bit_val)
    );

    always_ff @(posedge clk) begin
        if (rst)      sdo <= 1'b0;
        else if (adv) sdo <= in_range ? bit_val : 1'b0;
    end

    // R1: the line only moves right after a falling bit-clock edge
    a_r1_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(tick));

    // R7: nothing is sent before the first frame start
    a_r7_quiet_before_sync: assert property (@(posedge clk) disable iff (rst)
        !synced_q |-> (sdo == 1'b0));

    // R7: bits past the last slot stay low
    a_r7_quiet_past_last_slot: assert property (@(posedge clk) disable iff (rst)
        (adv && !in_range) |=> (sdo == 1'b0));

endmodule

// File: tb/audio_ser_tx_tb_top.sv
module audio_ser_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BCLK  = 4;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [2:0] fmt;
        logic       w24;
        logic       t16;
        logic [5:0] off;
        logic [4:0] nslot;
        logic [3:0] tag;
    } vec_t;

    // fmt, wlen_24, tdm_16, expected MSB offset, slots, requirement
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b1, 1'b0, 6'd1,  5'd2,  4'd2},   // R2 I2S 24-bit
        '{3'd0, 1'b0, 1'b0, 6'd1,  5'd2,  4'd2},   // R2 I2S 16-bit
        '{3'd1, 1'b1, 1'b0, 6'd0,  5'd2,  4'd3},   // R3 left-justified
        '{3'd1, 1'b0, 1'b1, 6'd0,  5'd2,  4'd10},  // R10 16-bit, R3 slot count ignored
        '{3'd2, 1'b1, 1'b0, 6'd8,  5'd2,  4'd4},   // R4 right-justified 24-bit
        '{3'd2, 1'b0, 1'b0, 6'd16, 5'd2,  4'd4},   // R4 right-justified 16-bit
        '{3'd3, 1'b1, 1'b0, 6'd1,  5'd8,  4'd5},   // R5 TDM level, 8 slots
        '{3'd3, 1'b0, 1'b1, 6'd1,  5'd16, 4'd5},   // R5 TDM level, 16 slots
        '{3'd4, 1'b1, 1'b0, 6'd1,  5'd8,  4'd6},   // R6 TDM pulse, 8 slots
        '{3'd4, 1'b1, 1'b1, 6'd1,  5'd16, 4'd6}    // R6 TDM pulse, 16 slots
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt = '0;
    logic        wlen_24 = 1'b1;
    logic        tdm_16 = 1'b0;
    logic        bclk = 1'b1;
    logic        fclk = 1'b0;
    logic [23:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        smp_req;
    logic [3:0]  smp_req_slot;
    logic        underrun;
    logic        sdo;

    int n_tests = 0;
    int n_fail  = 0;
    int bit_idx = 0;
    int stab_err = 0;
    int cur_cfg = 0;
    int resp_frame = 0;
    int req_count = 0;
    int urun_count = 0;
    int req_at_bit = -1;
    int last_req_slot = -1;
    logic resp_en = 1'b0;
    logic pre_go = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_ser_tx dut_i (
        .clk          (clk),
        .rst          (rst),
        .fmt          (fmt),
        .wlen_24      (wlen_24),
        .tdm_16       (tdm_16),
        .bclk         (bclk),
        .fclk         (fclk),
        .smp_data     (smp_data),
        .smp_valid    (smp_valid),
        .smp_req      (smp_req),
        .smp_req_slot (smp_req_slot),
        .underrun     (underrun),
        .sdo          (sdo)
    );

    function automatic logic [23:0] val(int c, int f, int s);
        logic [31:0] x;
        x = 32'h00A5C3E1 ^ (c * 32'h0001F3D5) ^ (f * 32'h00350B71) ^ (s * 32'h0009E37B);
        return x[23:0];
    endfunction

    function automatic logic exp_bit(logic [23:0] w, int loc, int off, int wl);
        int rel;
        rel = loc - off;
        if (rel < 0 || rel >= wl) return 1'b0;
        return w[wl-1-rel];
    endfunction

    function automatic logic fclk_at(vec_t v, int p, int nb);
        case (v.fmt)
            3'd0:    return (p >= 32);
            3'd1, 3'd2: return (p < 32);
            3'd3:    return (p >= nb/2);
            default: return (p == 0);
        endcase
    endfunction

    // Host model: answers requests and logs request/underrun activity.
    always @(negedge clk) begin
        if (pre_go) begin
            smp_valid = 1'b1;
            smp_data  = val(cur_cfg, 0, 0);
            pre_go    = 1'b0;
        end else if (smp_req && resp_en) begin
            if (smp_req_slot == 4'd0) resp_frame++;
            smp_valid = 1'b1;
            smp_data  = val(cur_cfg, resp_frame, int'(smp_req_slot));
        end else begin
            smp_valid = 1'b0;
        end
        if (smp_req) begin
            req_count++;
            last_req_slot = int'(smp_req_slot);
            req_at_bit = bit_idx;
        end
        if (underrun) urun_count++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic fv, output logic got);
        logic lo;
        @(negedge clk);
        bclk = 1'b0;
        fclk = fv;
        repeat (HALF_BCLK-1) @(negedge clk);
        lo = sdo;
        bclk = 1'b1;
        repeat (HALF_BCLK) @(negedge clk);
        if (sdo !== lo) stab_err++;
        got = lo;
        bit_idx++;
    endtask

    task automatic do_reset(input vec_t v);
        @(negedge clk);
        rst = 1'b1; bclk = 1'b1; fclk = 1'b0;
        fmt = v.fmt; wlen_24 = v.w24; tdm_16 = v.t16;
        resp_en = 1'b0; pre_go = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        urun_count = 0; req_count = 0; resp_frame = 0;
        last_req_slot = -1; req_at_bit = -1; stab_err = 0;
    endtask

    // Idle bits: two at the level opposite the pre-frame level (a wrong-polarity
    // edge follows), then four at the pre-frame level. Returns count of non-zero bits.
    task automatic idle_bits(input vec_t v, input int nb, output int errs);
        logic got;
        logic pre;
        pre = fclk_at(v, nb-1, nb);
        errs = 0;
        for (int k = 0; k < 6; k++) begin
            drive_bit((k < 2) ? ~pre : pre, got);
            if (got !== 1'b0) errs++;
        end
    endtask

    task automatic run_cfg(input int c);
        vec_t v;
        int   wl, nb, errs, idle_errs, first_p;
        logic got, e;
        string rq;
        v = VECS[c];
        wl = v.w24 ? 24 : 16;
        nb = int'(v.nslot) * 32;
        rq = $sformatf("R%0d", v.tag);
        do_reset(v);
        cur_cfg = c; resp_en = 1'b1; pre_go = 1'b1;
        repeat (4) @(negedge clk);
        idle_bits(v, nb, idle_errs);
        errs = 0; first_p = -1;
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < nb; p++) begin
                drive_bit(fclk_at(v, p, nb), got);
                e = exp_bit(val(c, f, p/32), p % 32, int'(v.off), wl);
                if (got !== e) begin
                    errs++;
                    if (first_p < 0) first_p = f * nb + p;
                end
            end
        end
        check(errs == 0, rq, $sformatf("cfg %0d serial bits (first bad pos %0d)", c, first_p), errs, 0);
        // R7 and wrong-polarity start edge: idle bits stay low
        check(idle_errs == 0, "R7", $sformatf("cfg %0d idle bits high", c), idle_errs, 0);
        // R1: no change while bclk is high
        check(stab_err == 0, "R1", $sformatf("cfg %0d changes during high phase", c), stab_err, 0);
        // R9: host keeps up, no underrun
        check(urun_count == 0, "R9", $sformatf("cfg %0d underrun pulses", c), urun_count, 0);
    endtask

    initial begin
        vec_t v;
        int   ierr, b0, zeros;
        logic got;
        logic [23:0] w0, w1;

        do_reset(VECS[2]);
        // R11: reset state at the ports
        check(sdo === 1'b0, "R11", "sdo after reset", sdo, 0);
        check(smp_req === 1'b0, "R11", "smp_req after reset", smp_req, 0);
        check(underrun === 1'b0, "R11", "underrun after reset", underrun, 0);

        for (int c = 0; c < NVEC; c++) run_cfg(c);

        // R11: empty holding register and zero word -> first slot underruns, sends zeros
        v = VECS[2];
        do_reset(v);
        cur_cfg = 30;
        idle_bits(v, 64, ierr);
        zeros = 0;
        for (int p = 0; p < 32; p++) begin
            drive_bit(fclk_at(v, p, 64), got);
            if (got !== 1'b0) zeros++;
        end
        check(zeros == 0, "R11", "first slot without sample not zero", zeros, 0);
        check(urun_count == 1, "R11", "underrun on first empty slot", urun_count, 1);

        // R9 / R8: one preloaded sample, host then silent
        do_reset(v);
        cur_cfg = 20; pre_go = 1'b1;
        repeat (4) @(negedge clk);
        idle_bits(v, 64, ierr);
        w0 = '0; w1 = '0;
        for (int p = 0; p < 64; p++) begin
            if (p == 0) b0 = bit_idx;
            drive_bit(fclk_at(v, p, 64), got);
            if (p < 24) w0[23-p] = got;
            if (p >= 32 && p < 56) w1[55-p] = got;
            if (p == 0) begin
                // R8: request in the boundary bit, naming slot 1
                check(req_count == 1, "R8", "requests after first boundary", req_count, 1);
                check(req_at_bit == b0, "R8", "request bit position", req_at_bit, b0);
                check(last_req_slot == 1, "R8", "next slot index", last_req_slot, 1);
            end
            if (p == 32) begin
                check(last_req_slot == 0, "R8", "slot index wrap", last_req_slot, 0);
                check(urun_count == 1, "R9", "underrun at second boundary", urun_count, 1);
            end
        end
        check(w0 == val(20, 0, 0), "R10", "preloaded word MSB first", w0, val(20, 0, 0));
        check(w1 == val(20, 0, 0), "R9", "repeated word on underrun", w1, val(20, 0, 0));

        // R7 / R8: TDM pulse 8 slots, then bits past the last slot without a new start
        v = VECS[8];
        do_reset(v);
        cur_cfg = 8; resp_en = 1'b1; pre_go = 1'b1;
        repeat (4) @(negedge clk);
        idle_bits(v, 256, ierr);
        for (int p = 0; p < 256; p++) drive_bit(fclk_at(v, p, 256), got);
        check(last_req_slot == 0, "R8", "request after last TDM slot wraps", last_req_slot, 0);
        check(req_count == 8, "R8", "requests per 8-slot frame", req_count, 8);
        zeros = 0;
        for (int p = 0; p < 40; p++) begin
            drive_bit(1'b0, got);
            if (got !== 1'b0) zeros++;
        end
        check(zeros == 0, "R7", "bits past last slot", zeros, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", 190000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule